// File: doc/BRIEF.md
# Maskable Interrupt Entry Sequencer

This block carries out the entry half of a maskable interrupt for a small 8-bit accumulator processor. The processor has a 16-bit address space and a stack that always lives in page one (addresses 0x0100 to 0x01FF). When a request arrives and the interrupt-disable flag in the supplied status byte is clear, the block takes a snapshot of the program counter, stack pointer and status. It then works through a fixed sequence on a synchronous single-port memory bus: three stack pushes followed by two vector reads.

The pushes store the return address, high byte first, and then the adjusted status byte. The stack pointer moves down by one after each push. Before the status byte is pushed, the break flag is cleared and the unused flag and the interrupt-disable flag are set. The two reads then fetch the handler address from the fixed vector pair. The updated program counter, stack pointer and status stay on the outputs until the next accepted request. A one-cycle completion pulse marks them valid, and the fixed cost of the entry in clock cycles is presented alongside that pulse.

The memory is expected to return read data on the cycle after the read strobe. At most one transaction is issued per clock. A request that arrives while the sequence is running is not sampled.

Top module: `irq_entry_seq`

## Requirements
- R1: A request while status_in bit 2 (interrupt disable) is 1 is ignored. No write or read strobe is raised, busy stays low, and pc_out, sp_out and status_out keep their values.
- R2: In the first cycle after acceptance the block writes pc_in[15:8] to address {STACK_PAGE, sp_in}, with mem_we=1.
- R3: In the second cycle after acceptance the block writes pc_in[7:0] to address {STACK_PAGE, sp_in-1}.
- R4: In the third cycle after acceptance the block writes the adjusted status to address {STACK_PAGE, sp_in-2}. The adjusted status is status_in with bit 4 cleared, bits 5 and 2 set, and every other bit kept. status_out takes this same value.
- R5: In the fourth cycle after acceptance the block reads address VECTOR_ADDR (0xFFFE), and in the fifth cycle it reads VECTOR_ADDR+1. pc_out becomes {second byte, first byte}.
- R6: sp_out ends at sp_in-3 modulo 256. Every stack write stays in page one, so with sp_in=0x01 the writes go to 0x0101, 0x0100 and 0x01FF.
- R7: busy is 1 for exactly the six cycles after acceptance. Requests presented during those cycles start no further sequence.
- R8: done is a single-cycle pulse in the first cycle after busy falls, which is the seventh cycle counting the acceptance cycle. cycle_cost shows ENTRY_CYCLES (7) while done is high and 0 at all other times.
- R9: At most one of mem_we and mem_re is high in any cycle, and neither is high while busy is low.
- R10: After reset, busy, done, mem_we and mem_re are 0, and pc_out, sp_out and status_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Maskable interrupt request, level sampled when idle |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| status_in | input | 8 | Current status byte (C0 Z1 I2 D3 B4 U5 V6 N7) |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe, data expected next cycle |
| mem_rdata | input | 8 | Read data returned one cycle after mem_re |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 8 | Updated stack pointer |
| status_out | output | 8 | Updated status byte |
| cycle_cost | output | 3 | Entry cost, shown while done is high |

## Verification
The bench builds the block with its defaults: stack page 0x01, vector at 0xFFFE and a cost of 7. With those values every computed push address, vector address and cost value can be compared directly with the numbers in the requirements. Stack pointers near zero come within reach, so the page-one wraparound of R6 is exercised by directed cases. Randomized program counters, stack pointers, status bytes and vector bytes cover the flag rewrite of R4 over many bit mixes, and masked requests are interleaved between accepted ones.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int DW = 8;
  localparam int AW = 16;

  localparam int FLG_I = 2;
  localparam int FLG_B = 4;
  localparam int FLG_U = 5;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PUSH_HI  = 3'd1,
    ST_PUSH_LO  = 3'd2,
    ST_PUSH_FLG = 3'd3,
    ST_VEC_LO   = 3'd4,
    ST_VEC_HI   = 3'd5,
    ST_LOAD     = 3'd6
  } seq_state_e;

  function automatic logic [DW-1:0] entry_flags(input logic [DW-1:0] s);
    logic [DW-1:0] r;
    r        = s;
    r[FLG_B] = 1'b0;
    r[FLG_U] = 1'b1;
    r[FLG_I] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_req,
  input  logic       mask_bit,
  output seq_state_e state,
  output logic       accept,
  output logic       done
);

  seq_state_e state_d;
  logic       done_d;

  assign accept = (state == ST_IDLE) && irq_req && !mask_bit;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:     if (accept) state_d = ST_PUSH_HI;
      ST_PUSH_HI:  state_d = ST_PUSH_LO;
      ST_PUSH_LO:  state_d = ST_PUSH_FLG;
      ST_PUSH_FLG: state_d = ST_VEC_LO;
      ST_VEC_LO:   state_d = ST_VEC_HI;
      ST_VEC_HI:   state_d = ST_LOAD;
      ST_LOAD:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
    done_d = (state == ST_LOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= done_d;
    end
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && irq_req && mask_bit) |=> (state == ST_IDLE)); // R1
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH_HI) |=> (state == ST_PUSH_LO)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

endmodule

// File: rtl/irq_entry_ctx.sv
module irq_entry_ctx
  import irq_entry_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  seq_state_e    state,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] status_in,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] sp_q,
  output logic [DW-1:0] st_q
);

  logic [AW-1:0] pc_d;
  logic [DW-1:0] sp_d, st_d, lo_d, lo_q;
  logic          ctx_en;

  assign ctx_en = accept || (state != ST_IDLE);

  always_comb begin
    pc_d = pc_q;
    sp_d = sp_q;
    st_d = st_q;
    lo_d = lo_q;
    if (accept) begin
      pc_d = pc_in;
      sp_d = sp_in;
      st_d = entry_flags(status_in);
    end
    case (state)
      ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_FLG: sp_d = sp_q - 1'b1;
      ST_VEC_HI: lo_d = rdata;
      ST_LOAD:   pc_d = {rdata, lo_q};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
      st_q <= '0;
      lo_q <= '0;
    end else if (ctx_en) begin
      pc_q <= pc_d;
      sp_q <= sp_d;
      st_q <= st_d;
      lo_q <= lo_d;
    end
  end

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH_HI || state == ST_PUSH_LO || state == ST_PUSH_FLG)
    |=> (sp_q == $past(sp_q) - 8'd1)); // R6
  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !accept) |=> ($stable(pc_q) && $stable(sp_q) && $stable(st_q))); // R1
  AST_FLAGS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH_FLG) |-> (st_q[FLG_I] && st_q[FLG_U] && !st_q[FLG_B])); // R4

endmodule

// File: rtl/irq_entry_bus.sv
module irq_entry_bus
  import irq_entry_pkg::*;
#(
  parameter logic [DW-1:0] STACK_PAGE  = 8'h01,
  parameter logic [AW-1:0] VECTOR_ADDR = 16'hFFFE
) (
  input  seq_state_e    state,
  input  logic [AW-1:0] pc_q,
  input  logic [DW-1:0] sp_q,
  input  logic [DW-1:0] st_q,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          we,
  output logic          re
);

  localparam logic [AW-1:0] VEC_HI_ADDR = VECTOR_ADDR + 1'b1;

  logic [AW-1:0] stack_addr;

  assign stack_addr = {STACK_PAGE, sp_q};

  always_comb begin
    addr  = '0;
    wdata = '0;
    we    = 1'b0;
    re    = 1'b0;
    case (state)
      ST_PUSH_HI: begin
        addr = stack_addr; wdata = pc_q[AW-1:DW]; we = 1'b1;
      end
      ST_PUSH_LO: begin
        addr = stack_addr; wdata = pc_q[DW-1:0]; we = 1'b1;
      end
      ST_PUSH_FLG: begin
        addr = stack_addr; wdata = st_q; we = 1'b1;
      end
      ST_VEC_LO: begin
        addr = VECTOR_ADDR; re = 1'b1;
      end
      ST_VEC_HI: begin
        addr = VEC_HI_ADDR; re = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter logic [DW-1:0] STACK_PAGE   = 8'h01,
  parameter logic [AW-1:0] VECTOR_ADDR  = 16'hFFFE,
  parameter int            ENTRY_CYCLES = 7,
  localparam int           COST_W       = $clog2(ENTRY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [AW-1:0]     pc_in,
  input  logic [DW-1:0]     sp_in,
  input  logic [DW-1:0]     status_in,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     pc_out,
  output logic [DW-1:0]     sp_out,
  output logic [DW-1:0]     status_out,
  output logic [COST_W-1:0] cycle_cost
);

  seq_state_e state;
  logic       accept;

  irq_entry_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .mask_bit (status_in[FLG_I]),
    .state    (state),
    .accept   (accept),
    .done     (done)
  );

  irq_entry_ctx u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .state     (state),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .status_in (status_in),
    .rdata     (mem_rdata),
    .pc_q      (pc_out),
    .sp_q      (sp_out),
    .st_q      (status_out)
  );

  irq_entry_bus #(
    .STACK_PAGE  (STACK_PAGE),
    .VECTOR_ADDR (VECTOR_ADDR)
  ) u_bus (
    .state (state),
    .pc_q  (pc_out),
    .sp_q  (sp_out),
    .st_q  (status_out),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .we    (mem_we),
    .re    (mem_re)
  );

  assign busy       = (state != ST_IDLE);
  assign cycle_cost = done ? COST_W'(ENTRY_CYCLES) : '0;

  AST_ONE_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re)); // R9
  AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[AW-1:DW] == STACK_PAGE)); // R6
  AST_VECTOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_addr[AW-1:1] == VECTOR_ADDR[AW-1:1])); // R5
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8

endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req;
  logic [15:0] pc_in;
  logic [7:0]  sp_in, status_in;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, mem_re, busy, done;
  logic [15:0] pc_out;
  logic [7:0]  sp_out, status_out;
  logic [2:0]  cycle_cost;

  logic [7:0]  vec_lo, vec_hi;
  logic [7:0]  stk [256];

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .pc_in(pc_in), .sp_in(sp_in),
    .status_in(status_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .pc_out(pc_out), .sp_out(sp_out), .status_out(status_out),
    .cycle_cost(cycle_cost)
  );

  always @(posedge clk) begin
    if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
    if (mem_re)
      mem_rdata <= (mem_addr == 16'hFFFE) ? vec_lo :
                   (mem_addr == 16'hFFFF) ? vec_hi : 8'h00;
    else
      mem_rdata <= 8'h00;
  end

  function automatic logic [7:0] exp_flags(input logic [7:0] s);
    return (s & 8'hEF) | 8'h24;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_entry(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] st,
                           input logic [7:0] vl, input logic [7:0] vh, input bit hold_req);
    logic [7:0] s1, s2, s3, fl;
    s1 = sp - 8'd1; s2 = sp - 8'd2; s3 = sp - 8'd3; fl = exp_flags(st);
    vec_lo = vl; vec_hi = vh;
    pc_in = pc; sp_in = sp; status_in = st; irq_req = 1'b1;
    @(posedge clk); @(negedge clk);
    if (!hold_req) irq_req = 1'b0;
    // cycle 1
    chk("R2", "we1", {mem_we, mem_re}, 2'b10);
    chk("R2", "addr1", mem_addr, {8'h01, sp});
    chk("R2", "data1", mem_wdata, pc[15:8]);
    chk("R7", "busy1", busy, 1);
    @(negedge clk);
    chk("R3", "addr2", {mem_we, mem_addr}, {1'b1, 8'h01, s1});
    chk("R3", "data2", mem_wdata, pc[7:0]);
    @(negedge clk);
    chk("R4", "addr3", {mem_we, mem_addr}, {1'b1, 8'h01, s2});
    chk("R4", "data3", mem_wdata, fl);
    @(negedge clk);
    chk("R5", "rd_lo", {mem_we, mem_re, mem_addr}, {2'b01, 16'hFFFE});
    @(negedge clk);
    chk("R5", "rd_hi", {mem_we, mem_re, mem_addr}, {2'b01, 16'hFFFF});
    @(negedge clk);
    irq_req = 1'b0;
    chk("R7", "busy6", busy, 1);
    chk("R9", "quiet6", {mem_we, mem_re}, 2'b00);
    chk("R8", "nodone6", done, 0);
    @(negedge clk);
    chk("R7", "busy7", busy, 0);
    chk("R8", "done7", {done, cycle_cost}, {1'b1, 3'd7});
    chk("R5", "pc", pc_out, {vh, vl});
    chk("R6", "sp", sp_out, s3);
    chk("R4", "status", status_out, fl);
    chk("R6", "stack", {stk[sp], stk[s1], stk[s2]}, {pc[15:8], pc[7:0], fl});
    @(negedge clk);
    chk("R8", "done_pulse", {done, cycle_cost}, 4'b0);
    chk("R7", "no_restart", busy, 0);
  endtask

  task automatic run_masked(input logic [7:0] st, input int n);
    logic [15:0] p0; logic [7:0] sp0, st0;
    p0 = pc_out; sp0 = sp_out; st0 = status_out;
    pc_in = 16'($urandom); sp_in = 8'($urandom); status_in = st | 8'h04; irq_req = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1", "masked_bus", {busy, mem_we, mem_re, done}, 4'b0);
      chk("R1", "masked_ctx", {pc_out, sp_out, status_out}, {p0, sp0, st0});
    end
    irq_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    vec_lo = 0; vec_hi = 0;
    rst_n = 1'b0; irq_req = 1'b0; pc_in = '0; sp_in = '0; status_in = '0;
    repeat (3) @(negedge clk);
    chk("R10", "reset_ctl", {busy, done, mem_we, mem_re, cycle_cost}, 7'b0);
    chk("R10", "reset_ctx", {pc_out, sp_out, status_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    run_masked(8'hFF, 4);
    run_entry(16'h1234, 8'hFD, 8'h00, 8'h00, 8'h80, 1'b0);
    run_entry(16'hBEEF, 8'h01, 8'hDB, 8'h34, 8'h12, 1'b1);
    run_entry(16'h00FF, 8'h00, 8'hFB, 8'hFF, 8'hFF, 1'b0);
    run_masked(8'h10, 3);
    for (int k = 0; k < 40; k++) begin
      if (k % 5 == 4) run_masked(8'($urandom), 2);
      run_entry(16'($urandom), 8'($urandom), 8'($urandom) & 8'hFB,
                8'($urandom), 8'($urandom), 1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule